// File: doc/BRIEF.md
# External Code-Fetch Bus Sequencer

This block runs the bus cycle that fetches one code byte from an external ROM over a shared 8-bit address/data port. The core gives a 16-bit fetch address and a one-clock request. The sequencer puts the upper address byte on a dedicated port for the whole access. It puts the lower address byte on the shared port while an active-high latch strobe is raised. It then stops driving the shared port and pulls an active-low read strobe, which goes to the ROM output enable. It captures the byte the ROM returns and raises a one-clock completion pulse.

The shared port appears as three plain signals: a drive value, a drive enable, and the value sensed at the pad. An external tri-state buffer joins them. The block also holds a model of the transparent latch that splits address from data. Its output shows the low address byte the ROM would see. One request that arrives during an access is held and starts as soon as the sequencer is idle again.

Top module: `fetch_bus`

## Requirements
- R1: While rst_ni is low, ale_o is 0, psen_no is 1, ad_oe_o is 0 and done_o is 0.
- R2: An access starts with exactly ADDR_CYC clocks of ale_o = 1. In each of them ad_oe_o = 1 and ad_o equals bits 7:0 of the fetch address. ale_o is never 1 while ad_oe_o is 0.
- R3: From the first ale_o clock to the done_o clock, addr_hi_o equals bits 15:8 of the fetch address and does not change.
- R4: After ale_o falls, ad_oe_o stays 0 and psen_no stays 1 for at least REL_CYC clocks before psen_no goes low. psen_no is never 0 while ad_oe_o is 1.
- R5: psen_no is 0 for exactly READ_CYC consecutive clocks. ad_i is sampled on the last of them, and that byte appears on data_o.
- R6: done_o is 1 for exactly one clock, the clock right after psen_no returns high. data_o holds the fetched byte in that clock.
- R7: latched_lo_o follows ad_o while ale_o is 1 and keeps its value after ale_o falls, so during the read it equals bits 7:0 of the fetch address.
- R8: A request that arrives while an access is in progress is not lost. Its access starts when the sequencer returns to idle, using the address given with that request.
- R9: Only one request is held. If several arrive during one access, only the newest address is fetched afterwards, and the earlier ones produce no access.
- R10: When a request is taken in idle, done_o rises exactly ADDR_CYC + REL_CYC + READ_CYC clocks after the clock in which ale_o first goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Fetch request, one clock |
| addr_i | input | 16 | Fetch address, valid with req_i |
| addr_hi_o | output | 8 | Upper address byte on the dedicated port |
| ad_o | output | 8 | Value driven on the shared port |
| ad_oe_o | output | 1 | Drive enable for the shared port |
| ad_i | input | 8 | Value sensed on the shared port |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_no | output | 1 | ROM read strobe, active low |
| latched_lo_o | output | 8 | Output of the modelled address latch |
| data_o | output | 8 | Last fetched code byte |
| done_o | output | 1 | Fetch complete, one clock |

## Verification
The bench builds the block with ADDR_CYC = 2, REL_CYC = 2 and READ_CYC = 3 instead of the defaults 1, 1 and 2. With every phase longer than one clock, the bench can check the phase counters at their limits: an off-by-one in any phase length, the release gap or the sampling clock changes the strobe widths, the latency or the captured byte. The ROM model answers from the upper port and the latch output, so a latch that does not hold shows up as a wrong byte.

// File: rtl/fetch_bus_pkg.sv
package fetch_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REL,
    ST_READ,
    ST_CAP
  } fetch_state_e;
endpackage

// File: rtl/fetch_req_hold.sv
module fetch_req_hold #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic          start_o,
  output logic [AW-1:0] start_addr_o
);
  logic          pend_q;
  logic [AW-1:0] pend_addr_q;
  logic          take_pend, take_req;

  // a held request goes before a new one
  assign take_pend    = idle_i & pend_q;
  assign take_req     = idle_i & ~pend_q & req_i;
  assign start_o      = take_pend | take_req;
  assign start_addr_o = pend_q ? pend_addr_q : addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (req_i && !take_req) begin
      pend_q      <= 1'b1;
      pend_addr_q <= addr_i;
    end else if (take_pend) begin
      pend_q      <= 1'b0;
    end
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_bus_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int ADDR_CYC = 1,
  parameter int REL_CYC  = 1,
  parameter int READ_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [DW-1:0] ad_i,
  output logic          idle_o,
  output logic [AW-1:0] addr_o,
  output logic          ale_o,
  output logic          ad_oe_o,
  output logic          psen_no,
  output logic [DW-1:0] data_o,
  output logic          done_o
);
  localparam int MAX_A   = (ADDR_CYC > REL_CYC) ? ADDR_CYC : REL_CYC;
  localparam int MAX_LEN = (MAX_A > READ_CYC) ? MAX_A : READ_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  fetch_state_e   state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  int             phase_len;
  logic           phase_last;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;

  always_comb begin
    case (state_q)
      ST_ADDR: phase_len = ADDR_CYC;
      ST_REL:  phase_len = REL_CYC;
      ST_READ: phase_len = READ_CYC;
      default: phase_len = 1;
    endcase
  end

  assign phase_last = (32'(cnt_q) == phase_len - 1);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ADDR;
      ST_ADDR: if (phase_last) state_d = ST_REL;
      ST_REL:  if (phase_last) state_d = ST_READ;
      ST_READ: if (phase_last) state_d = ST_CAP;
      ST_CAP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
      if (state_q == ST_IDLE && start_i) addr_q <= start_addr_i;
      if (state_q == ST_READ && phase_last) data_q <= ad_i;
    end
  end

  assign idle_o  = (state_q == ST_IDLE);
  assign addr_o  = addr_q;
  assign ale_o   = (state_q == ST_ADDR);
  assign ad_oe_o = (state_q == ST_ADDR);
  assign psen_no = (state_q != ST_READ);
  assign done_o  = (state_q == ST_CAP);
  assign data_o  = data_q;
endmodule

// File: rtl/fetch_addr_latch.sv
module fetch_addr_latch #(
  parameter int DW = 8
) (
  input  logic          gate_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  // transparent while gate high, holds after it falls
  always_latch begin
    if (gate_i) q_o = d_i;
  end
endmodule

// File: rtl/fetch_bus.sv
module fetch_bus #(
  parameter int ADDR_CYC = 1,
  parameter int REL_CYC  = 1,
  parameter int READ_CYC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [15:0] addr_i,
  output logic [7:0]  addr_hi_o,
  output logic [7:0]  ad_o,
  output logic        ad_oe_o,
  input  logic [7:0]  ad_i,
  output logic        ale_o,
  output logic        psen_no,
  output logic [7:0]  latched_lo_o,
  output logic [7:0]  data_o,
  output logic        done_o
);
  localparam int AW = 16;
  localparam int DW = 8;

  logic          idle, start;
  logic [AW-1:0] start_addr, cur_addr;

  fetch_req_hold #(.AW(AW)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idle_i       (idle),
    .req_i        (req_i),
    .addr_i       (addr_i),
    .start_o      (start),
    .start_addr_o (start_addr)
  );

  fetch_seq #(
    .AW(AW), .DW(DW),
    .ADDR_CYC(ADDR_CYC), .REL_CYC(REL_CYC), .READ_CYC(READ_CYC)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_addr_i (start_addr),
    .ad_i         (ad_i),
    .idle_o       (idle),
    .addr_o       (cur_addr),
    .ale_o        (ale_o),
    .ad_oe_o      (ad_oe_o),
    .psen_no      (psen_no),
    .data_o       (data_o),
    .done_o       (done_o)
  );

  assign addr_hi_o = cur_addr[AW-1:DW];
  assign ad_o      = cur_addr[DW-1:0];

  fetch_addr_latch #(.DW(DW)) u_latch (
    .gate_i (ale_o),
    .d_i    (ad_o),
    .q_o    (latched_lo_o)
  );
endmodule

// File: rtl/fetch_bus_checker.sv
module fetch_bus_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ale_o,
  input logic       ad_oe_o,
  input logic       psen_no,
  input logic       done_o,
  input logic [7:0] addr_hi_o,
  input logic [7:0] latched_lo_o
);
  a_r2_ale_needs_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o);
  a_r4_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> !ad_oe_o);
  a_r4_release_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psen_no) |-> !$past(ad_oe_o));
  a_r3_hi_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psen_no || done_o) |-> $stable(addr_hi_o));
  a_r7_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> $stable(latched_lo_o));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_done_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!psen_no));
endmodule

bind fetch_bus fetch_bus_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ale_o        (ale_o),
  .ad_oe_o      (ad_oe_o),
  .psen_no      (psen_no),
  .done_o       (done_o),
  .addr_hi_o    (addr_hi_o),
  .latched_lo_o (latched_lo_o)
);

// File: tb/fetch_bus_test.sv
module fetch_bus_test;
  localparam int ADDR_CYC = 2;
  localparam int REL_CYC  = 2;
  localparam int READ_CYC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  addr_hi, ad_out, ad_in, latched, data;
  logic        ad_oe, ale, psen_n, done;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  fetch_bus #(.ADDR_CYC(ADDR_CYC), .REL_CYC(REL_CYC), .READ_CYC(READ_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .addr_hi_o(addr_hi), .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in),
    .ale_o(ale), .psen_no(psen_n), .latched_lo_o(latched),
    .data_o(data), .done_o(done)
  );

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // ROM answers only with its output enable, from the latched address
  assign ad_in = !psen_n ? rom_byte({addr_hi, latched}) : 8'hFF;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [15:0] a, input bit expect_it);
    @(negedge clk);
    req  = 1'b1;
    addr = a;
    if (expect_it) exp_q.push_back(a);
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor
  int  ale_len = 0, gap_len = 0, read_len = 0, since_ale = 0;
  bit  in_fetch = 0, prev_ale = 0, prev_psen = 1, prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ale && !prev_ale) begin
        in_fetch = 1; since_ale = 0; ale_len = 0; gap_len = 0; read_len = 0;
      end
      if (in_fetch) since_ale++;
      if (ale) begin
        ale_len++;
        chk(ad_oe, "R2 drive during ale", ad_oe, 1);
        if (exp_q.size() > 0) begin
          chk(ad_out == exp_q[0][7:0], "R2 low byte", ad_out, exp_q[0][7:0]);
          chk(latched == ad_out, "R7 latch transparent", latched, ad_out);
        end
      end
      if (!ale && prev_ale)
        chk(ale_len == ADDR_CYC, "R2 ale width", ale_len, ADDR_CYC);
      if (in_fetch && !ale && psen_n && !done) begin
        gap_len++;
        if (ad_oe) chk(0, "R4 port released", ad_oe, 0);
      end
      if (!psen_n) begin
        read_len++;
        chk(!ad_oe, "R4 no contention", ad_oe, 0);
      end
      if (!psen_n && prev_psen)
        chk(gap_len >= REL_CYC, "R4 release gap", gap_len, REL_CYC);
      if (psen_n && !prev_psen)
        chk(read_len == READ_CYC, "R5 read width", read_len, READ_CYC);
      if (done && prev_done) chk(0, "R6 done single clock", 1, 0);
      if (done && !prev_done) begin
        chk(!prev_psen, "R6 done follows read", prev_psen, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected fetch", {addr_hi, latched}, 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(data == rom_byte(e), "R5 captured byte", data, rom_byte(e));
          chk(addr_hi == e[15:8], "R3 high byte", addr_hi, e[15:8]);
          chk(latched == e[7:0], "R7 latch held", latched, e[7:0]);
          chk(since_ale - 1 == ADDR_CYC + REL_CYC + READ_CYC, "R10 latency",
              since_ale - 1, ADDR_CYC + REL_CYC + READ_CYC);
        end
        in_fetch = 0;
      end
      prev_ale = ale; prev_psen = psen_n; prev_done = done;
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 20000; wd++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ale == 0, "R1 ale reset", ale, 0);
    chk(psen_n == 1, "R1 psen reset", psen_n, 1);
    chk(ad_oe == 0, "R1 oe reset", ad_oe, 0);
    chk(done == 0, "R1 done reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    pulse(16'h1234, 1); drain();
    pulse(16'hFFFF, 1); drain();
    pulse(16'h0000, 1); drain();
    pulse(16'hA55A, 1); drain();

    // R8: second request during an access is held
    pulse(16'h3C01, 1);
    @(negedge clk);
    pulse(16'hC3FE, 1);
    drain();

    // R9: newest held request wins
    pulse(16'h0102, 1);
    pulse(16'h0304, 0);
    pulse(16'h0506, 1);
    drain();
    chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule